// File: doc/BRIEF.md
# TCAM Array Initialization Sequencer

After reset a ternary CAM holds arbitrary contents in both its data array and its mask array. This block fills both arrays by itself, one write at a time. It drives each write over a request/response debug port: a low 32-bit address, two upper address words held at zero, three 32-bit data words and a command code. It then waits for the response strobe. The number of entries, the width mode (72-bit or 144-bit), the index where the server region starts, the two array base addresses, the address shift and the write command code are all inputs. These inputs are captured when a start pulse arrives.

The data array is cleared first. The mask array is then written with patterns that depend on the region. Below the server region the slots are written in pairs, and the two slots of a pair get two different masks. From the server region up to the last slot, a single pattern that depends on the mode is used. A write that gets no response within the polling window stops the whole sequence and reports an error.

Top module: `tcam_init_seq`

## Requirements
- R1: After reset `req_valid_o`, `done_o` and `err_o` are low, and no write is issued until `start_i` is pulsed.
- R2: In 144-bit mode the slot count is twice `entries_i` and the server base is twice `srv_base_i`. In 72-bit mode both are used as given.
- R3: The clear phase runs first. It writes slots 0 to count-1 in ascending order to address `data_base_i + (i << addr_shift_i)` with all three data words zero.
- R4: The mask phase then writes slots 0 to count-1 to `mask_base_i + (i << addr_shift_i)`. Below the server base rounded up to an even value, even slots get words (0x3fffffff, 0xfff80000, 0x000000ff) and odd slots get (0xffffffff, 0xffffffff, 0x000000ff).
- R5: Mask slots at or above that rounded base get words (0xfffffff9, 0xffffffff, 0x000000ff) in 144-bit mode and (0xfffffffd, 0xffffffff, 0x000000ff) in 72-bit mode.
- R6: `addr_shift_i` scales the slot index in the address. Value 0 gives consecutive addresses and value 1 gives a stride of two.
- R7: Each write is a one-cycle `req_valid_o` pulse carrying `req_cmd_o = wr_cmd_i`. Both upper address words are zero. Address and data stay unchanged until the response.
- R8: A response is accepted in any of the 5 cycles that follow the issue cycle. The next write is issued only after it.
- R9: If none of those 5 cycles carries a response, no further write is issued, and `done_o` pulses for one cycle with `err_o` high.
- R10: When every write has been acknowledged, `done_o` pulses for one cycle with `err_o` low.
- R11: A `start_i` pulse while a sequence is running is ignored. The running sequence keeps its captured inputs and write count.
- R12: With `entries_i` zero, `done_o` pulses with `err_o` low and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| entries_i | input | CNT_W | Entry count in units of the chosen width |
| wide_mode_i | input | 1 | 1 selects 144-bit entries, 0 selects 72-bit entries |
| srv_base_i | input | CNT_W | Index of the first server-region entry |
| data_base_i | input | ADDR_W | Base address of the data array |
| mask_base_i | input | ADDR_W | Base address of the mask array |
| addr_shift_i | input | SHIFT_W | Left shift applied to the slot index |
| wr_cmd_i | input | CMD_W | Write command code |
| req_valid_o | output | 1 | Command issue strobe |
| req_cmd_o | output | CMD_W | Command code |
| req_addr0_o | output | ADDR_W | Low address word |
| req_addr1_o | output | ADDR_W | Middle address word, always zero |
| req_addr2_o | output | ADDR_W | High address word, always zero |
| req_data0_o | output | 32 | Data word 0 |
| req_data1_o | output | 32 | Data word 1 |
| req_data2_o | output | 32 | Data word 2 |
| rsp_valid_i | input | 1 | Response strobe for the outstanding write |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | High with `done_o` when the sequence aborted |

## Verification
The hardest condition to reach is a response that arrives exactly on the fifth and last polling cycle. This is close to a timeout that aborts in the middle of the mask phase. The bench acts as the CAM responder and varies the response delay from 1 to 5 cycles in rotation, so every long run has writes acknowledged at the edge of the window. Chosen vectors withhold the response for one specific write, so that an abort happens both on the very first write and partway through the mask fill. An odd server base in 72-bit mode forces the pair region to spill one slot past the base. Another vector pulses start in the middle of a run with a different entry count.

// File: rtl/tcam_init_pkg.sv
package tcam_init_pkg;
  typedef enum logic { PH_CLEAR, PH_MASK } phase_e;
  typedef enum logic [1:0] { P_IDLE, P_ISSUE, P_WAIT } poll_st_e;
  typedef enum logic [1:0] { T_IDLE, T_SEL, T_RUN, T_END } top_st_e;

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] w2;
  } tword_t;

  localparam tword_t WORD_ZERO = '{w0: 32'h0, w1: 32'h0, w2: 32'h0};
  localparam tword_t MASK_EVEN = '{w0: 32'h3fff_ffff, w1: 32'hfff8_0000, w2: 32'h0000_00ff};
  localparam tword_t MASK_ODD  = '{w0: 32'hffff_ffff, w1: 32'hffff_ffff, w2: 32'h0000_00ff};
  localparam logic [31:0] TAIL_W0_WIDE   = 32'hffff_fff9;
  localparam logic [31:0] TAIL_W0_NARROW = 32'hffff_fffd;
endpackage

// File: rtl/tcam_slot_gen.sv
module tcam_slot_gen
  import tcam_init_pkg::*;
#(
  parameter int IDX_W   = 17,
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 1
) (
  input  phase_e              phase_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                wide_i,
  input  logic [IDX_W-1:0]    pair_end_i,
  input  logic [ADDR_W-1:0]   data_base_i,
  input  logic [ADDR_W-1:0]   mask_base_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic [ADDR_W-1:0]   addr_o,
  output tword_t              word_o
);
  logic [ADDR_W-1:0] offset;

  assign offset = ADDR_W'(idx_i) << shift_i;

  always_comb begin
    if (phase_i == PH_CLEAR) begin
      addr_o = data_base_i + offset;
      word_o = WORD_ZERO;
    end else begin
      addr_o = mask_base_i + offset;
      if (idx_i < pair_end_i) begin
        word_o = idx_i[0] ? MASK_ODD : MASK_EVEN;
      end else begin
        word_o.w0 = wide_i ? TAIL_W0_WIDE : TAIL_W0_NARROW;
        word_o.w1 = 32'hffff_ffff;
        word_o.w2 = 32'h0000_00ff;
      end
    end
  end
endmodule

// File: rtl/tcam_cmd_poll.sv
module tcam_cmd_poll
  import tcam_init_pkg::*;
#(
  parameter int MAX_POLL = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic rsp_valid_i,
  output logic req_valid_o,
  output logic ok_o,
  output logic fail_o
);
  localparam int POLL_W = $clog2(MAX_POLL + 1);

  poll_st_e           st_q;
  logic [POLL_W-1:0]  cnt_q;
  logic               last_try;

  assign last_try    = (cnt_q == POLL_W'(MAX_POLL - 1));
  assign req_valid_o = (st_q == P_ISSUE);
  assign ok_o        = (st_q == P_WAIT) && rsp_valid_i;
  assign fail_o      = (st_q == P_WAIT) && !rsp_valid_i && last_try;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= P_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        P_IDLE:  if (go_i) st_q <= P_ISSUE;
        P_ISSUE: begin
          st_q  <= P_WAIT;
          cnt_q <= '0;
        end
        P_WAIT: begin
          if (rsp_valid_i || last_try) st_q <= P_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  // R7
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);

  // R8
  poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < POLL_W'(MAX_POLL));

  // R9
  no_reissue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !req_valid_o);
endmodule

// File: rtl/tcam_init_seq.sv
module tcam_init_seq
  import tcam_init_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int SHIFT_W  = 1,
  parameter int CMD_W    = 32,
  parameter int MAX_POLL = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   entries_i,
  input  logic               wide_mode_i,
  input  logic [CNT_W-1:0]   srv_base_i,
  input  logic [ADDR_W-1:0]  data_base_i,
  input  logic [ADDR_W-1:0]  mask_base_i,
  input  logic [SHIFT_W-1:0] addr_shift_i,
  input  logic [CMD_W-1:0]   wr_cmd_i,
  output logic               req_valid_o,
  output logic [CMD_W-1:0]   req_cmd_o,
  output logic [ADDR_W-1:0]  req_addr0_o,
  output logic [ADDR_W-1:0]  req_addr1_o,
  output logic [ADDR_W-1:0]  req_addr2_o,
  output logic [31:0]        req_data0_o,
  output logic [31:0]        req_data1_o,
  output logic [31:0]        req_data2_o,
  input  logic               rsp_valid_i,
  output logic               done_o,
  output logic               err_o
);
  localparam int IDX_W = CNT_W + 1;

  top_st_e            st_q;
  phase_e             phase_q;
  logic [IDX_W-1:0]   idx_q, total_q, pair_end_q;
  logic               wide_q, err_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [ADDR_W-1:0]  dbase_q, mbase_q, addr_q;
  logic [CMD_W-1:0]   cmd_q;
  tword_t             word_q;

  logic [IDX_W-1:0]   total_d, sbase_d;
  logic [ADDR_W-1:0]  gen_addr;
  tword_t             gen_word;
  logic               have_slot, go, poll_ok, poll_fail;

  // one wide entry spans two narrow slots
  assign total_d   = wide_mode_i ? {entries_i, 1'b0} : {1'b0, entries_i};
  assign sbase_d   = wide_mode_i ? {srv_base_i, 1'b0} : {1'b0, srv_base_i};
  assign have_slot = idx_q < total_q;
  assign go        = (st_q == T_SEL) && have_slot;

  tcam_slot_gen #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_gen (
    .phase_i    (phase_q),
    .idx_i      (idx_q),
    .wide_i     (wide_q),
    .pair_end_i (pair_end_q),
    .data_base_i(dbase_q),
    .mask_base_i(mbase_q),
    .shift_i    (shift_q),
    .addr_o     (gen_addr),
    .word_o     (gen_word)
  );

  tcam_cmd_poll #(.MAX_POLL(MAX_POLL)) u_poll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .rsp_valid_i(rsp_valid_i),
    .req_valid_o(req_valid_o),
    .ok_o       (poll_ok),
    .fail_o     (poll_fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= T_IDLE;
      phase_q    <= PH_CLEAR;
      idx_q      <= '0;
      total_q    <= '0;
      pair_end_q <= '0;
      wide_q     <= 1'b0;
      err_q      <= 1'b0;
      shift_q    <= '0;
      dbase_q    <= '0;
      mbase_q    <= '0;
      addr_q     <= '0;
      cmd_q      <= '0;
      word_q     <= WORD_ZERO;
    end else begin
      case (st_q)
        T_IDLE: if (start_i) begin
          st_q       <= T_SEL;
          phase_q    <= PH_CLEAR;
          idx_q      <= '0;
          total_q    <= total_d;
          // pairs run to the next even slot
          pair_end_q <= sbase_d + IDX_W'(sbase_d[0]);
          wide_q     <= wide_mode_i;
          err_q      <= 1'b0;
          shift_q    <= addr_shift_i;
          dbase_q    <= data_base_i;
          mbase_q    <= mask_base_i;
          cmd_q      <= wr_cmd_i;
        end
        T_SEL: begin
          if (have_slot) begin
            addr_q <= gen_addr;
            word_q <= gen_word;
            idx_q  <= idx_q + 1'b1;
            st_q   <= T_RUN;
          end else if (phase_q == PH_CLEAR) begin
            phase_q <= PH_MASK;
            idx_q   <= '0;
          end else begin
            st_q <= T_END;
          end
        end
        T_RUN: begin
          if (poll_ok) begin
            st_q <= T_SEL;
          end else if (poll_fail) begin
            err_q <= 1'b1;
            st_q  <= T_END;
          end
        end
        T_END:   st_q <= T_IDLE;
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign done_o      = (st_q == T_END);
  assign err_o       = (st_q == T_END) && err_q;
  assign req_cmd_o   = cmd_q;
  assign req_addr0_o = addr_q;
  assign req_addr1_o = '0;
  assign req_addr2_o = '0;
  assign req_data0_o = word_q.w0;
  assign req_data1_o = word_q.w1;
  assign req_data2_o = word_q.w2;

  // R9
  abort_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_fail |=> (done_o && err_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  hold_while_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_RUN && !poll_ok && !poll_fail) |=> ($stable(req_addr0_o) && $stable(word_q)));

  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != T_IDLE && start_i) |=> ($stable(total_q) && $stable(cmd_q) && $stable(wide_q)));
endmodule

// File: tb/sim_tcam_init_seq.sv
module sim_tcam_init_seq;
  localparam int NVEC = 9;
  // {entries[31:24], srv_base[23:16], fail_at[15:8] (ff = none), 5'b0, poke, wide, shift}
  localparam logic [31:0] VECS [NVEC] = '{
    32'h06_04_ff_00,   // narrow, even base
    32'h05_03_ff_01,   // narrow, odd base, stride 2
    32'h04_02_ff_02,   // wide, stride 1
    32'h03_00_ff_03,   // wide, all tail, stride 2
    32'h04_04_ff_00,   // all pairs
    32'h04_01_05_00,   // abort mid mask phase
    32'h00_00_ff_00,   // zero entries
    32'h02_00_00_01,   // abort on first write
    32'h03_00_ff_04    // start pulse while busy
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] entries_i = '0;
  logic        wide_mode_i = 1'b0;
  logic [15:0] srv_base_i = '0;
  logic [31:0] data_base_i = '0;
  logic [31:0] mask_base_i = '0;
  logic [0:0]  addr_shift_i = '0;
  logic [31:0] wr_cmd_i = '0;
  logic        req_valid_o;
  logic [31:0] req_cmd_o, req_addr0_o, req_addr1_o, req_addr2_o;
  logic [31:0] req_data0_o, req_data1_o, req_data2_o;
  logic        rsp_valid_i = 1'b0;
  logic        done_o, err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  tcam_init_seq u0 (
    .clk_i, .rst_ni, .start_i, .entries_i, .wide_mode_i, .srv_base_i,
    .data_base_i, .mask_base_i, .addr_shift_i, .wr_cmd_i,
    .req_valid_o, .req_cmd_o, .req_addr0_o, .req_addr1_o, .req_addr2_o,
    .req_data0_o, .req_data1_o, .req_data2_o, .rsp_valid_i, .done_o, .err_o
  );

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] v);
    int ent = int'(v[31:24]);
    int sb = int'(v[23:16]);
    int fa = int'(v[15:8]);
    bit poke = v[2];
    bit wide = v[1];
    int sh = int'(v[0]);
    int total = wide ? 2 * ent : ent;
    int sbx = wide ? 2 * sb : sb;
    int pe = (sbx + 1) & ~1;
    int exp_n = (fa == 255) ? 2 * total : fa + 1;
    logic [31:0] dbase = sh ? 32'h0100_0000 : 32'h0;
    logic [31:0] mbase = sh ? 32'h0200_0000 : 32'h0008_0000;
    logic [31:0] cmd = sh ? 32'h4 : 32'h1;
    int n = 0;
    int guard = 0;
    bit seen = 0;
    entries_i = 16'(ent); srv_base_i = 16'(sb); wide_mode_i = wide;
    addr_shift_i = 1'(sh); data_base_i = dbase; mask_base_i = mbase; wr_cmd_i = cmd;
    @(posedge clk_i); #1 start_i = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b0;
    while (!seen && guard < 5000) begin
      @(negedge clk_i); guard++;
      if (done_o) begin
        seen = 1;
        if (fa != 255) chk(err_o == 1'b1, "R9 err flag", 96'(err_o), 96'(1));
        else if (ent == 0) chk(err_o == 1'b0, "R12 err flag", 96'(err_o), 96'(0));
        else chk(err_o == 1'b0, "R8/R10 err flag", 96'(err_o), 96'(0));
      end else if (req_valid_o) begin
        logic [31:0] ea;
        logic [95:0] ed;
        string tag;
        int d;
        if (n < total) begin
          ea = dbase + (32'(n) << sh); ed = '0; tag = "R3/R6";
        end else begin
          int j = n - total;
          ea = mbase + (32'(j) << sh);
          if (j < pe) begin
            ed = j[0] ? {32'hffffffff, 32'hffffffff, 32'hff} : {32'h3fffffff, 32'hfff80000, 32'hff};
            tag = "R4/R6";
          end else begin
            ed = {wide ? 32'hfffffff9 : 32'hfffffffd, 32'hffffffff, 32'hff};
            tag = wide ? "R5/R2" : "R5";
          end
        end
        chk(req_addr0_o == ea, {tag, " addr"}, 96'(req_addr0_o), 96'(ea));
        chk({req_data0_o, req_data1_o, req_data2_o} == ed, {tag, " data"},
            {req_data0_o, req_data1_o, req_data2_o}, ed);
        chk(req_cmd_o == cmd && req_addr1_o == 0 && req_addr2_o == 0, "R7 cmd/upper addr",
            {req_cmd_o, req_addr1_o, req_addr2_o}, {cmd, 64'h0});
        n++;
        @(negedge clk_i); guard++;
        chk(req_valid_o == 1'b0, "R7 strobe width", 96'(req_valid_o), 96'(0));
        if (n - 1 != fa) begin
          d = 1 + ((n - 1) % 5);
          repeat (d - 1) @(posedge clk_i);
          #1 rsp_valid_i = 1'b1;
          if (poke && n == 3) begin
            start_i = 1'b1; entries_i = 16'd7;
          end
          chk(req_addr0_o == ea, "R7 addr hold", 96'(req_addr0_o), 96'(ea));
          @(posedge clk_i); #1 rsp_valid_i = 1'b0; start_i = 1'b0;
        end
      end
    end
    chk(seen, "R10 done seen", 96'(seen), 96'(1));
    if (poke) chk(n == exp_n, "R11 count", 96'(n), 96'(exp_n));
    else if (fa != 255) chk(n == exp_n, "R9 count", 96'(n), 96'(exp_n));
    else if (ent == 0) chk(n == 0, "R12 count", 96'(n), 96'(0));
    else chk(n == exp_n, wide ? "R2 count" : "R3 count", 96'(n), 96'(exp_n));
    repeat (10) begin
      @(negedge clk_i);
      chk(!req_valid_o && !done_o, "R11 quiet after end", {req_valid_o, done_o}, 96'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      chk(!req_valid_o && !done_o && !err_o, "R1 reset idle",
          {req_valid_o, done_o, err_o}, 96'(0));
    end
    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule